// File: doc/BRIEF.md
# Programmable Interrupt Controller Command Decoder

This block is the byte-wide programming port of an eight-line, priority-ordered interrupt controller. It keeps the request, in-service and mask registers and the mode flags. Software writes command bytes to two addresses and reads status back from them. A byte written to address 0 is one of three things. It can start an initialization sequence. It can be a mode word that arms a poll or selects which register a read returns. Otherwise it is a command that ends an interrupt or moves the rotating priority offset. A byte written to address 1 is taken by the initialization sequencer while a sequence is running, and loads the mask when none is running.

Requests are captured on rising edges of the request lines. A small internal resolver ranks the lines from the current rotation offset. The block raises its interrupt output when the best unmasked request outranks the best line in service. Interrupts are acknowledged by a poll read. The bus side is a pair of single-cycle strobes with no back-pressure: a write takes effect at the clock edge where it is sampled. A read returns its byte one cycle later, marked by a one-cycle valid pulse. The read data stays held until the next read. A write and a read must never be strobed in the same cycle.

Top module: `pic_cmd_decoder`

## Requirements
- R1: After reset the mask, in-service and request registers are zero, the interrupt output is low, no sequence is running, and all mode flags and the vector base are zero.
- R2: A 0-to-1 transition on request line i sets request bit i. A line held high sets it only once, even if that bit is cleared later.
- R3: An address-0 write with bit 4 = 1 starts initialization. It clears mask, in-service and request, the rotation offset, special mask, poll, the read select (back to request), rotate-on-auto-EOI, nested mode, auto-EOI and the vector base. It latches bit 0 as "fourth word wanted" and bit 1 as "single controller".
- R4: In initialization, the first address-1 write stores (value & 0xF8) as the vector base. The sequence then goes to the second word if cascaded. If single, it goes to the fourth word when that word is wanted, and to idle otherwise. After the second word it goes to the fourth word if wanted, else to idle. init_busy is high while a sequence is running.
- R5: The fourth initialization word sets nested mode from bit 4 and auto-EOI from bit 1, and ends the sequence.
- R6: An address-1 write with no sequence running loads the mask register. Address-1 writes during a sequence never change the mask.
- R7: An address-0 write with bit 4 = 0 and bit 3 = 1 is a mode word. Bit 2 = 1 arms poll. Bit 1 = 1 updates the read select from bit 0 (1 = in-service, 0 = request). Bit 6 = 1 updates special mask from bit 5.
- R8: A line's rank is (line − offset) mod 8, and a lower rank wins. int_req is high when an unmasked request exists whose best rank is lower than the best in-service rank. In special mask mode, masked in-service lines are left out of that comparison.
- R9: A read with poll armed returns 0x80 | winning line and acknowledges that line, or returns 0x00 if int_req is low. Acknowledging clears the request bit. Without auto-EOI it sets the in-service bit. With auto-EOI it leaves in-service alone and, if rotate-on-auto-EOI is set, sets the offset to line+1. Poll is disarmed after the read.
- R10: Commands are address-0 writes with bits 4 and 3 both 0, and bits 7:5 form the command code. Codes 1 and 5 clear the best-ranked in-service bit. Code 5 also sets the offset to that line+1.
- R11: Code 3 clears in-service bit (value & 7). Code 7 does the same and sets the offset to that line+1. Code 6 sets the offset to (value + 1) mod 8.
- R12: Codes 0 and 4 set rotate-on-auto-EOI from bit 7. Code 2 changes nothing.
- R13: A non-poll read returns the mask from address 1, and from address 0 the in-service or request register per the read select. rd_valid pulses for one cycle, one cycle after rd_en. wr_en and rd_en are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | 8 | Interrupt request lines, captured on rising edges |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | Register address (0 or 1) |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, held until the next read |
| rd_valid | output | 1 | One-cycle pulse marking rd_data as fresh |
| int_req | output | 1 | Interrupt request to the processor |
| vec_base | output | 8 | Vector base from the first initialization word |
| init_busy | output | 1 | High while an initialization sequence runs |
| auto_eoi_mode | output | 1 | Auto-EOI flag |
| nested_mode | output | 1 | Nested-mode flag |
| rot_aeoi_mode | output | 1 | Rotate-on-auto-EOI flag |

## Verification
The hardest states to reach are those with a non-zero rotation offset while lines are in service. The offset is visible at the ports only through the order in which poll reads pick winners. The stimulus builds these states in steps. It first moves the offset with a rotating non-specific EOI, then with the specific-rotate and set-offset commands. At each step it raises pairs of lines whose winner differs between the unrotated and the rotated ranking. The auto-EOI rotation is reached by re-initializing into single mode with a fourth word. Requests already held high must not be recaptured afterwards, and the next poll winner shows where the offset landed.

// File: rtl/pic_cfg_pkg.sv
package pic_cfg_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_MODE = 2'd3
  } seq_t;

  typedef enum logic [1:0] {
    W_INIT = 2'd0,
    W_MODE = 2'd1,
    W_CMD  = 2'd2
  } word_t;

  localparam logic [2:0] OP_ROT_CLR  = 3'd0;
  localparam logic [2:0] OP_EOI_ANY  = 3'd1;
  localparam logic [2:0] OP_NOP      = 3'd2;
  localparam logic [2:0] OP_EOI_ONE  = 3'd3;
  localparam logic [2:0] OP_ROT_SET  = 3'd4;
  localparam logic [2:0] OP_EOI_ROT  = 3'd5;
  localparam logic [2:0] OP_SET_OFS  = 3'd6;
  localparam logic [2:0] OP_ONE_ROT  = 3'd7;

  // bits [4:3] of an address-0 byte pick the word kind
  function automatic word_t classify(input logic [1:0] sel);
    if (sel[1])      return W_INIT;
    else if (sel[0]) return W_MODE;
    else             return W_CMD;
  endfunction

endpackage

// File: rtl/pic_rank_pick.sv
module pic_rank_pick #(
  parameter int N    = 8,
  localparam int IDXW = $clog2(N)
) (
  input  logic [N-1:0]    vec,
  input  logic [IDXW-1:0] offset,
  output logic            found,
  output logic [IDXW-1:0] line
);
  // Scan from the lowest rank (the offset itself) upward; N must be a power of two
  always_comb begin
    found = 1'b0;
    line  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (vec[IDXW'(k) + offset]) begin
        found = 1'b1;
        line  = IDXW'(k) + offset;
      end
    end
  end
endmodule

// File: rtl/pic_req_capture.sv
module pic_req_capture #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] clr,
  input  logic         clr_all,
  output logic [N-1:0] req
);
  logic [N-1:0] prev_q;
  logic [N-1:0] rise;

  assign rise = lines & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      req    <= '0;
    end else begin
      prev_q <= lines;
      if (clr_all) req <= '0;
      else         req <= (req & ~clr) | rise;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_edge_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lines[i] && !prev_q[i] && !clr_all) |=> req[i]);
    assert_held_no_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!req[i] && prev_q[i] && lines[i]) |=> !req[i]);
  end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cfg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          want4_in,
  input  logic          single_in,
  input  logic          wr_hi,
  input  logic [DW-1:3] base_in,
  input  logic          nest_bit,
  input  logic          aeoi_bit,
  output logic          idle,
  output logic [DW-1:0] base,
  output logic          nested,
  output logic          aeoi
);
  seq_t step_q;
  logic want4_q, single_q;

  assign idle = (step_q == SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q   <= SEQ_IDLE;
      want4_q  <= 1'b0;
      single_q <= 1'b0;
      base     <= '0;
      nested   <= 1'b0;
      aeoi     <= 1'b0;
    end else if (start) begin
      step_q   <= SEQ_BASE;
      want4_q  <= want4_in;
      single_q <= single_in;
      base     <= '0;
      nested   <= 1'b0;
      aeoi     <= 1'b0;
    end else if (wr_hi) begin
      unique case (step_q)
        SEQ_BASE: begin
          base   <= {base_in, 3'b000};
          step_q <= !single_q ? SEQ_CASC : (want4_q ? SEQ_MODE : SEQ_IDLE);
        end
        SEQ_CASC: step_q <= want4_q ? SEQ_MODE : SEQ_IDLE;
        SEQ_MODE: begin
          nested <= nest_bit;
          aeoi   <= aeoi_bit;
          step_q <= SEQ_IDLE;
        end
        default: step_q <= SEQ_IDLE;
      endcase
    end
  end

  assert_start_enters_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (step_q == SEQ_BASE));
  assert_mode_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !start && step_q == SEQ_MODE) |=> idle);
  assert_base_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !start && step_q == SEQ_BASE && !single_q) |=> (step_q == SEQ_CASC));
endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder
  import pic_cfg_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8,
  localparam int IDXW = $clog2(N),
  localparam int PADW = DW - 1 - IDXW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_line,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          int_req,
  output logic [DW-1:0] vec_base,
  output logic          init_busy,
  output logic          auto_eoi_mode,
  output logic          nested_mode,
  output logic          rot_aeoi_mode
);
  logic [N-1:0]    imr, isr, irr;
  logic [N-1:0]    imr_n, isr_n, irr_clr;
  logic [IDXW-1:0] ofs, ofs_n;
  logic            smask, smask_n, poll, poll_n, rsel, rsel_n, rot, rot_n;
  logic [DW-1:0]   rd_n;
  logic            clr_all;
  logic            seq_idle;
  word_t           kind;

  logic            req_any, eff_any, raw_any;
  logic [IDXW-1:0] req_line, eff_line, raw_line;
  logic [IDXW-1:0] req_rank, eff_rank;
  logic [N-1:0]    isr_eff;

  assign kind    = classify(wr_data[4:3]);
  assign clr_all = wr_en && !addr && (kind == W_INIT);
  assign isr_eff = smask ? (isr & ~imr) : isr;

  pic_req_capture #(.N(N)) u_req (
    .clk(clk), .rst_n(rst_n), .lines(irq_line),
    .clr(irr_clr), .clr_all(clr_all), .req(irr)
  );

  pic_init_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(clr_all),
    .want4_in(wr_data[0]), .single_in(wr_data[1]),
    .wr_hi(wr_en && addr), .base_in(wr_data[DW-1:3]),
    .nest_bit(wr_data[4]), .aeoi_bit(wr_data[1]),
    .idle(seq_idle), .base(vec_base), .nested(nested_mode), .aeoi(auto_eoi_mode)
  );

  pic_rank_pick #(.N(N)) u_pick_req (.vec(irr & ~imr), .offset(ofs), .found(req_any), .line(req_line));
  pic_rank_pick #(.N(N)) u_pick_eff (.vec(isr_eff),    .offset(ofs), .found(eff_any), .line(eff_line));
  pic_rank_pick #(.N(N)) u_pick_raw (.vec(isr),        .offset(ofs), .found(raw_any), .line(raw_line));

  assign req_rank = req_line - ofs;
  assign eff_rank = eff_line - ofs;
  assign int_req  = req_any && (!eff_any || (req_rank < eff_rank));
  assign init_busy     = !seq_idle;
  assign rot_aeoi_mode = rot;

  always_comb begin
    imr_n   = imr;
    isr_n   = isr;
    ofs_n   = ofs;
    smask_n = smask;
    poll_n  = poll;
    rsel_n  = rsel;
    rot_n   = rot;
    irr_clr = '0;
    rd_n    = rd_data;
    if (wr_en && !addr) begin
      unique case (kind)
        W_INIT: begin
          imr_n = '0; isr_n = '0; ofs_n = '0; smask_n = 1'b0;
          poll_n = 1'b0; rsel_n = 1'b0; rot_n = 1'b0;
        end
        W_MODE: begin
          if (wr_data[2]) poll_n  = 1'b1;
          if (wr_data[1]) rsel_n  = wr_data[0];
          if (wr_data[6]) smask_n = wr_data[5];
        end
        default: begin
          unique case (wr_data[7:5])
            OP_ROT_CLR, OP_ROT_SET: rot_n = wr_data[7];
            OP_EOI_ANY, OP_EOI_ROT: begin
              if (raw_any) begin
                isr_n[raw_line] = 1'b0;
                if (wr_data[7]) ofs_n = raw_line + IDXW'(1);
              end
            end
            OP_EOI_ONE: isr_n[wr_data[IDXW-1:0]] = 1'b0;
            OP_SET_OFS: ofs_n = wr_data[IDXW-1:0] + IDXW'(1);
            OP_ONE_ROT: begin
              isr_n[wr_data[IDXW-1:0]] = 1'b0;
              ofs_n = wr_data[IDXW-1:0] + IDXW'(1);
            end
            default: ;
          endcase
        end
      endcase
    end
    if (wr_en && addr && seq_idle) imr_n = wr_data;
    if (rd_en) begin
      if (poll) begin
        poll_n = 1'b0;
        if (int_req) begin
          rd_n = {1'b1, {PADW{1'b0}}, req_line};
          irr_clr[req_line] = 1'b1;
          if (auto_eoi_mode) begin
            if (rot) ofs_n = req_line + IDXW'(1);
          end else begin
            isr_n[req_line] = 1'b1;
          end
        end else begin
          rd_n = '0;
        end
      end else begin
        rd_n = addr ? imr : (rsel ? isr : irr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imr <= '0; isr <= '0; ofs <= '0;
      smask <= 1'b0; poll <= 1'b0; rsel <= 1'b0; rot <= 1'b0;
      rd_data <= '0; rd_valid <= 1'b0;
    end else begin
      imr <= imr_n; isr <= isr_n; ofs <= ofs_n;
      smask <= smask_n; poll <= poll_n; rsel <= rsel_n; rot <= rot_n;
      rd_data <= rd_n; rd_valid <= rd_en;
    end
  end

  assert_no_rw_overlap_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));
  assert_rd_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_rd_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  assert_poll_disarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && poll && !wr_en) |=> !poll);
  assert_mask_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && init_busy) |=> $stable(imr));
  assert_init_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (imr == '0 && isr == '0 && irr == '0 && init_busy));
  assert_specific_eoi_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && kind == W_CMD && wr_data[7:5] == OP_EOI_ONE)
      |=> !isr[$past(wr_data[IDXW-1:0])]);
  assert_idle_when_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irr & ~imr) == '0 |-> !int_req);
endmodule

// File: tb/sim_pic_cmd_decoder.sv
module sim_pic_cmd_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_line = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data, vec_base;
  logic       rd_valid, int_req, init_busy, auto_eoi_mode, nested_mode, rot_aeoi_mode;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  pic_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .int_req(int_req), .vec_base(vec_base), .init_busy(init_busy),
    .auto_eoi_mode(auto_eoi_mode), .nested_mode(nested_mode), .rot_aeoi_mode(rot_aeoi_mode)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a read result appears
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R13 unexpected read", rd_data, 8'hxx);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic lines(input logic [7:0] v);
    @(negedge clk); irq_line = v;
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 int_req", {7'd0, int_req}, 8'h00);
    check("R1 init_busy", {7'd0, init_busy}, 8'h00);
    check("R1 vec_base", vec_base, 8'h00);
    rd(1'b1, 8'h00, "R1 mask");
    rd(1'b0, 8'h00, "R1 request");

    // R4/R5/R6 cascaded sequence with fourth word
    wr(1'b0, 8'h11);
    check("R3 busy after start", {7'd0, init_busy}, 8'h01);
    wr(1'b1, 8'h4F);
    check("R4 base masked", vec_base, 8'h48);
    check("R4 still busy in cascade", {7'd0, init_busy}, 8'h01);
    wr(1'b1, 8'hA5);
    check("R4 busy before fourth", {7'd0, init_busy}, 8'h01);
    wr(1'b1, 8'h12);
    check("R5 nested", {7'd0, nested_mode}, 8'h01);
    check("R5 auto eoi", {7'd0, auto_eoi_mode}, 8'h01);
    check("R5 idle", {7'd0, init_busy}, 8'h00);
    rd(1'b1, 8'h00, "R6 mask untouched by sequence");

    // R4 single without fourth word
    wr(1'b0, 8'h12);
    wr(1'b1, 8'h08);
    check("R4 single short idle", {7'd0, init_busy}, 8'h00);
    check("R4 single base", vec_base, 8'h08);
    check("R3 auto eoi cleared", {7'd0, auto_eoi_mode}, 8'h00);

    // main setup
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h00); wr(1'b1, 8'h00);
    wr(1'b1, 8'hF0);
    rd(1'b1, 8'hF0, "R6 mask load");
    wr(1'b1, 8'h00);

    // R2/R7/R8
    wr(1'b0, 8'h0B);
    lines(8'h28);
    check("R8 int_req raised", {7'd0, int_req}, 8'h01);
    rd(1'b0, 8'h00, "R7 select in-service");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h28, "R2 request captured");
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h83, "R9 poll winner");
    check("R8 lower rank blocked", {7'd0, int_req}, 8'h00);
    rd(1'b0, 8'h20, "R9 poll disarmed request cleared");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h08, "R9 in-service set");

    // R10 non-specific EOI
    wr(1'b0, 8'h20);
    check("R10 eoi reopens", {7'd0, int_req}, 8'h01);
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h85, "R9 second poll");
    wr(1'b0, 8'hA0);                 // clear 5, offset 6
    lines(8'h00);
    lines(8'h82);
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h87, "R10 rotated winner");

    // R11
    wr(1'b0, 8'h67);
    rd(1'b0, 8'h00, "R11 specific eoi");
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h81, "R11 next poll");
    wr(1'b0, 8'hE1);                 // clear 1, offset 2
    wr(1'b0, 8'hC4);                 // offset 5
    lines(8'h00);
    lines(8'h44);
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h86, "R11 set offset winner");
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h00, "R9 poll none");
    rd(1'b0, 8'h40, "R9 disarmed after none");

    // R12 code 2
    wr(1'b0, 8'h40);
    rd(1'b0, 8'h40, "R12 code 2 no change");
    check("R12 code 2 int_req", {7'd0, int_req}, 8'h00);

    // R8 special mask
    wr(1'b1, 8'h40);
    check("R8 before special mask", {7'd0, int_req}, 8'h00);
    wr(1'b0, 8'h68);
    check("R8 special mask on", {7'd0, int_req}, 8'h01);
    wr(1'b0, 8'h48);
    check("R8 special mask off", {7'd0, int_req}, 8'h00);

    // R12 rotate flag
    wr(1'b0, 8'h80);
    check("R12 rotate set", {7'd0, rot_aeoi_mode}, 8'h01);
    wr(1'b0, 8'h00);
    check("R12 rotate clear", {7'd0, rot_aeoi_mode}, 8'h00);

    // R3 re-init clears, R4 single with fourth word
    wr(1'b0, 8'h13);
    check("R3 int_req after init", {7'd0, int_req}, 8'h00);
    wr(1'b1, 8'h20);
    check("R4 single to fourth", {7'd0, init_busy}, 8'h01);
    wr(1'b1, 8'h02);
    check("R5 auto eoi on", {7'd0, auto_eoi_mode}, 8'h01);
    check("R5 nested off", {7'd0, nested_mode}, 8'h00);
    rd(1'b1, 8'h00, "R3 mask cleared");
    rd(1'b0, 8'h00, "R3 request cleared");

    // R9 auto-EOI with rotation
    wr(1'b0, 8'h80);
    lines(8'h00);
    lines(8'h10);
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h84, "R9 auto eoi poll");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h00, "R9 auto eoi leaves in-service");
    lines(8'h38);
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h85, "R9 auto rotate winner");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("R13 missing reads", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule